// File: doc/BRIEF.md
# Buffer-Fill Rate-Locked Sample Clock Recovery

This block recovers an output sample rate from a stream that arrives at an unknown, slowly varying rate on the system clock. Incoming samples land in a small first-in first-out store. A phase-accumulator oscillator produces a read pulse on each carry-out, and every read pulse moves one sample to the output. The store's occupancy acts as a phase detector that does not wrap. The occupancy is measured against half of the depth, and that signed error drives a proportional-integral filter. The filter output becomes the oscillator's per-clock increment, so the read rate settles at the write rate.

The integral path accumulates only on cycles that carry an input beat. The proportional path is recomputed from the current occupancy on every clock, which lets the brief one-count wobble caused by the relative position of write and read pulses nudge the oscillator by less than one count of occupancy. A lock detector switches the filter from wide acquisition gains to narrow tracking gains. After reset the oscillator's pulses are held off until the store first reaches half full.

Input flow control: `in_ready` is high whenever the store has room. The source runs at its own fixed rate and cannot be stalled, so a beat offered while `in_ready` is low is dropped and latches `ovf_flag`. The output has no back-pressure: `out_valid` is a one-cycle pulse paced by the oscillator, and the sink must take `out_data` in that cycle.

Top module: `rate_lock_nco`

## Requirements
- R1: Samples leave on `out_data` in the same order they were accepted, with none duplicated or lost other than beats dropped under R2.
- R2: `in_ready` is high exactly when the stored count is below DEPTH. A beat offered while the store is full is discarded and sets `ovf_flag`, which stays high until reset.
- R3: Until the stored count has first reached DEPTH/2, no sample is read out and `rate_word` stays at NOM_INC.
- R4: The oscillator adds `rate_word` to a PHW-bit phase on every clock. Each carry-out after priming reads one sample, and `out_valid` with its `out_data` appears on the clock edge at which the carry occurs.
- R5: Once primed, `rate_word` is registered every clock as NOM_INC + integral + ((count − DEPTH/2)·2^ERR_FRAC >>> kp), where the count is the stored count before that edge.
- R6: Once primed, the integral adds ((count − DEPTH/2)·2^ERR_FRAC >>> ki) only on clocks where `in_valid` is high, and it saturates at ±INT_LIM.
- R7: `rate_word` is clamped to the range INC_MIN to INC_MAX.
- R8: `locked` rises after LOCK_N consecutive input beats, each with |count − DEPTH/2| ≤ LOCK_TH. It falls on the edge after any clock where that magnitude exceeds UNLOCK_TH. A beat with the magnitude above LOCK_TH restarts the run.
- R9: While `locked` is low, kp = KP_ACQ and ki = KI_ACQ. While it is high, kp = KP_TRK and ki = KI_TRK.
- R10: A carry-out after priming while the store is empty produces no `out_valid` and sets `unf_flag`, which stays high until reset.
- R11: After reset the store is empty, `in_ready` is high, `out_valid`, `locked` and both flags are low, and `rate_word` equals NOM_INC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat strobe |
| in_ready | output | 1 | Store has room for a beat |
| in_data | input | DW | Input sample |
| out_valid | output | 1 | One-cycle output beat pulse |
| out_data | output | DW | Output sample |
| rate_word | output | PHW | Current oscillator increment |
| locked | output | 1 | Loop in tracking mode |
| ovf_flag | output | 1 | Sticky: beat dropped on full store |
| unf_flag | output | 1 | Sticky: read pulse on empty store |

## Verification
The hardest corner to reach is the lower clamp of `rate_word`. Draining the store alone does not reach it, because the integral freezes without input beats and keeps any positive charge it gained during overflow. The stimulus first overfills the store with back-to-back beats, which saturates the integral high and forces the upper clamp, and then idles until underflow. After that it trickles sparse beats into the near-empty store, so every beat pulls the integral toward its negative limit until the sum falls below INC_MIN. A cycle-level model predicts every output on every clock, so a change to any gain, gate or timing shows up at once.

// File: rtl/rln_pkg.sv
package rln_pkg;
  typedef enum logic {
    MODE_ACQ   = 1'b0,
    MODE_TRACK = 1'b1
  } loop_mode_e;
endpackage

// File: rtl/rln_fifo.sv
module rln_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  output logic [CW-1:0] fill,
  output logic          full,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          ovf,
  output logic          unf
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] fill_q;
  logic          wr_fire, rd_fire, empty;

  assign full    = (fill_q == CW'(DEPTH));
  assign empty   = (fill_q == '0);
  assign wr_fire = wr_req && !full;
  assign rd_fire = rd_req && !empty;
  assign fill    = fill_q;

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wptr_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q   <= '0;
      rptr_q   <= '0;
      fill_q   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      ovf      <= 1'b0;
      unf      <= 1'b0;
    end else begin
      if (wr_fire) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (rd_fire) rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      fill_q   <= fill_q + CW'(wr_fire) - CW'(rd_fire);
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= mem[rptr_q];
      if (wr_req && full) ovf <= 1'b1;
      if (rd_req && empty) unf <= 1'b1;
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CW'(DEPTH)); // R2
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R2
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    unf |=> unf); // R10
  AST_EMPTY_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q == '0) |=> !rd_valid); // R10
endmodule

// File: rtl/rln_nco.sv
module rln_nco #(
  parameter int PHW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [PHW-1:0] inc,
  output logic           fire
);
  logic [PHW-1:0] phase_q;
  logic [PHW:0]   sum;

  assign sum  = {1'b0, phase_q} + {1'b0, inc};
  assign fire = sum[PHW] && enable;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= sum[PHW-1:0];
  end
endmodule

// File: rtl/rln_lock_det.sv
module rln_lock_det
  import rln_pkg::*;
#(
  parameter int EW        = 6,
  parameter int LOCK_TH   = 1,
  parameter int UNLOCK_TH = 3,
  parameter int LOCK_N    = 8,
  localparam int RW       = $clog2(LOCK_N) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 strobe,
  input  logic signed [EW-1:0] err,
  output loop_mode_e           mode
);
  logic signed [EW-1:0] mag;
  logic [RW-1:0]        run_q;
  logic                 too_far, close_in;

  assign mag      = err[EW-1] ? -err : err;
  assign too_far  = mag > $signed(EW'(UNLOCK_TH));
  assign close_in = mag <= $signed(EW'(LOCK_TH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode  <= MODE_ACQ;
      run_q <= '0;
    end else if (too_far) begin
      mode  <= MODE_ACQ;
      run_q <= '0;
    end else if (enable && strobe) begin
      if (close_in) begin
        if (run_q == RW'(LOCK_N - 1)) mode <= MODE_TRACK;
        else                          run_q <= run_q + 1'b1;
      end else begin
        run_q <= '0;
      end
    end
  end

  AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    too_far |=> (mode == MODE_ACQ)); // R8
  AST_LOCK_ONLY_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ACQ && !(enable && strobe)) |=> (mode == MODE_ACQ)); // R8
endmodule

// File: rtl/rln_loop_filter.sv
module rln_loop_filter
  import rln_pkg::*;
#(
  parameter int PHW      = 16,
  parameter int EW       = 6,
  parameter int NOM_INC  = 16384,
  parameter int INC_MIN  = 12288,
  parameter int INC_MAX  = 24576,
  parameter int ERR_FRAC = 10,
  parameter int KP_ACQ   = 1,
  parameter int KI_ACQ   = 4,
  parameter int KP_TRK   = 4,
  parameter int KI_TRK   = 7,
  parameter int INT_LIM  = 6144,
  localparam int IW      = PHW + 2,
  localparam int SW      = IW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 strobe,
  input  loop_mode_e           mode,
  input  logic signed [EW-1:0] err,
  output logic [PHW-1:0]       inc
);
  localparam logic signed [SW-1:0] NOM_S  = SW'(NOM_INC);
  localparam logic signed [SW-1:0] MIN_S  = SW'(INC_MIN);
  localparam logic signed [SW-1:0] MAX_S  = SW'(INC_MAX);
  localparam logic signed [SW-1:0] LIM_HI = SW'(INT_LIM);
  localparam logic signed [SW-1:0] LIM_LO = -SW'(INT_LIM);

  logic signed [IW-1:0] integ_q, err_w, scaled, p_term, i_term;
  logic signed [SW-1:0] i_sum, r_sum;
  logic [PHW-1:0]       r_next;
  int unsigned          kp_sh, ki_sh;

  always_comb begin
    kp_sh = (mode == MODE_TRACK) ? KP_TRK : KP_ACQ;
    ki_sh = (mode == MODE_TRACK) ? KI_TRK : KI_ACQ;
  end

  assign err_w  = {{(IW - EW){err[EW-1]}}, err};
  assign scaled = err_w <<< ERR_FRAC;
  assign p_term = scaled >>> kp_sh;
  assign i_term = scaled >>> ki_sh;
  assign i_sum  = {{2{integ_q[IW-1]}}, integ_q} + {{2{i_term[IW-1]}}, i_term};
  assign r_sum  = NOM_S + {{2{integ_q[IW-1]}}, integ_q} + {{2{p_term[IW-1]}}, p_term};

  always_comb begin
    if (r_sum > MAX_S)      r_next = PHW'(INC_MAX);
    else if (r_sum < MIN_S) r_next = PHW'(INC_MIN);
    else                    r_next = r_sum[PHW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      integ_q <= '0;
      inc     <= PHW'(NOM_INC);
    end else begin
      if (enable && strobe) begin
        if (i_sum > LIM_HI)      integ_q <= IW'(INT_LIM);
        else if (i_sum < LIM_LO) integ_q <= -IW'(INT_LIM);
        else                     integ_q <= i_sum[IW-1:0];
      end
      inc <= enable ? r_next : PHW'(NOM_INC);
    end
  end

  AST_RATE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc >= PHW'(INC_MIN)) && (inc <= PHW'(INC_MAX))); // R7
  AST_INTEG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (integ_q <= IW'(INT_LIM)) && (integ_q >= -IW'(INT_LIM))); // R6
  AST_INTEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(integ_q)); // R6
endmodule

// File: rtl/rate_lock_nco.sv
module rate_lock_nco
  import rln_pkg::*;
#(
  parameter int DW        = 8,
  parameter int DEPTH     = 16,
  parameter int PHW       = 16,
  parameter int NOM_INC   = 16384,
  parameter int INC_MIN   = 12288,
  parameter int INC_MAX   = 24576,
  parameter int ERR_FRAC  = 10,
  parameter int KP_ACQ    = 1,
  parameter int KI_ACQ    = 4,
  parameter int KP_TRK    = 4,
  parameter int KI_TRK    = 7,
  parameter int INT_LIM   = 6144,
  parameter int LOCK_TH   = 1,
  parameter int UNLOCK_TH = 3,
  parameter int LOCK_N    = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [DW-1:0]  in_data,
  output logic           out_valid,
  output logic [DW-1:0]  out_data,
  output logic [PHW-1:0] rate_word,
  output logic           locked,
  output logic           ovf_flag,
  output logic           unf_flag
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int EW   = CW + 1;
  localparam int HALF = DEPTH / 2;

  logic [CW-1:0]        fill;
  logic                 full, primed_q, rd_pulse;
  logic signed [EW-1:0] fill_err;
  loop_mode_e           mode;

  assign in_ready = !full;
  assign locked   = (mode == MODE_TRACK);
  assign fill_err = $signed({1'b0, fill}) - $signed(EW'(HALF));

  always_ff @(posedge clk) begin
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= primed_q || (fill >= CW'(HALF));
  end

  rln_fifo #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (in_valid),
    .wr_data  (in_data),
    .rd_req   (rd_pulse),
    .fill     (fill),
    .full     (full),
    .rd_valid (out_valid),
    .rd_data  (out_data),
    .ovf      (ovf_flag),
    .unf      (unf_flag)
  );

  rln_nco #(.PHW(PHW)) u_osc (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (primed_q),
    .inc    (rate_word),
    .fire   (rd_pulse)
  );

  rln_lock_det #(
    .EW(EW), .LOCK_TH(LOCK_TH), .UNLOCK_TH(UNLOCK_TH), .LOCK_N(LOCK_N)
  ) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (primed_q),
    .strobe (in_valid),
    .err    (fill_err),
    .mode   (mode)
  );

  rln_loop_filter #(
    .PHW(PHW), .EW(EW), .NOM_INC(NOM_INC), .INC_MIN(INC_MIN), .INC_MAX(INC_MAX),
    .ERR_FRAC(ERR_FRAC), .KP_ACQ(KP_ACQ), .KI_ACQ(KI_ACQ), .KP_TRK(KP_TRK),
    .KI_TRK(KI_TRK), .INT_LIM(INT_LIM)
  ) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (primed_q),
    .strobe (in_valid),
    .mode   (mode),
    .err    (fill_err),
    .inc    (rate_word)
  );

  AST_NO_READ_BEFORE_PRIME: assert property (@(posedge clk) disable iff (!rst_n)
    !primed_q |=> !out_valid); // R3
  AST_NOMINAL_BEFORE_PRIME: assert property (@(posedge clk) disable iff (!rst_n)
    !primed_q |=> (rate_word == PHW'(NOM_INC))); // R3
  AST_READY_WHEN_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (fill < CW'(DEPTH)) |-> in_ready); // R2
endmodule

// File: tb/rate_lock_nco_bench.sv
`timescale 1ns/100ps
module rate_lock_nco_bench;
  localparam int DW = 8, DEPTH = 16, PHW = 16, HALF = DEPTH / 2;
  localparam int NOM = 16384, IMIN = 12288, IMAX = 24576, EF = 10;
  localparam int KPA = 1, KIA = 4, KPT = 4, KIT = 7, ILIM = 6144;
  localparam int LTH = 1, UTH = 3, LN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, locked, ovf_flag, unf_flag;
  logic [DW-1:0] out_data;
  logic [PHW-1:0] rate_word;

  always #2.5 clk = ~clk;

  rate_lock_nco u_rate_lock_nco (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .rate_word(rate_word), .locked(locked), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  int checks = 0, fails = 0;
  logic [DW-1:0] expq[$];
  logic [DW-1:0] seq = '0;
  bit run_model = 1'b0, finished = 1'b0;
  int reads_unprimed = 0, pops = 0, locked_cycles = 0;
  bit saw_max = 0, saw_min = 0;

  // model state (before the next edge)
  int mf = 0, mi = 0, mc = 0, mph = 0, minc = NOM;
  bit mp = 0, ml = 0, movf = 0, munf = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_beats(input int n, input int period);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      in_valid = 1'b1;
      in_data  = seq;
      if (in_ready) expq.push_back(seq);
      seq = seq + 1'b1;
      if (period > 1) begin
        @(negedge clk); #1;
        in_valid = 1'b0;
        repeat (period - 2) @(negedge clk);
      end
    end
    @(negedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: cycle model of R2..R10 plus scoreboard for R1
  always @(negedge clk) begin
    if (run_model) begin
      int err, ae, kp, ki, es, sum, inc_e, tot, ph_n, mi_n, mc_n, mf_n;
      bit v, carry, fire, rd, wr, ml_n;
      v   = in_valid;
      err = mf - HALF;
      ae  = (err < 0) ? -err : err;
      kp  = ml ? KPT : KPA;   // R9 gain choice
      ki  = ml ? KIT : KIA;
      es  = err * (1 << EF);
      sum = NOM + mi + (es >>> kp);
      if (sum > IMAX) sum = IMAX;
      if (sum < IMIN) sum = IMIN;
      inc_e = mp ? sum : NOM;
      tot   = mph + minc;
      carry = (tot >= (1 << PHW));
      ph_n  = tot % (1 << PHW);
      fire  = carry && mp;
      rd    = fire && (mf > 0);
      wr    = v && (mf < DEPTH);
      mi_n  = mi;
      if (mp && v) begin   // R6 integral on beats only, saturating
        mi_n = mi + (es >>> ki);
        if (mi_n > ILIM) mi_n = ILIM;
        if (mi_n < -ILIM) mi_n = -ILIM;
      end
      ml_n = ml; mc_n = mc;
      if (ae > UTH) begin ml_n = 0; mc_n = 0; end
      else if (mp && v) begin
        if (ae <= LTH) begin
          if (mc == LN - 1) ml_n = 1; else mc_n = mc + 1;
        end else mc_n = 0;
      end
      mf_n = mf + (wr ? 1 : 0) - (rd ? 1 : 0);

      if (!mp && out_valid) reads_unprimed++;
      check(out_valid == rd, mp ? "R4" : "R3", out_valid, rd);
      check(rate_word == inc_e, ml ? "R5/R9" : "R5/R6", rate_word, inc_e);
      check(locked == ml_n, "R8", locked, ml_n);
      check(ovf_flag == (movf || (v && mf == DEPTH)), "R2", ovf_flag, movf || (v && mf == DEPTH));
      check(unf_flag == (munf || (fire && mf == 0)), "R10", unf_flag, munf || (fire && mf == 0));
      check(in_ready == (mf_n < DEPTH), "R2", in_ready, mf_n < DEPTH);
      if (out_valid) begin
        if (expq.size() == 0) check(1'b0, "R1", out_data, -1);
        else begin
          logic [DW-1:0] e;
          e = expq.pop_front();
          pops++;
          check(out_data == e, "R1", out_data, e);
        end
      end
      if (rate_word == IMAX) saw_max = 1;
      if (rate_word == IMIN) saw_min = 1;
      if (locked) locked_cycles++;

      movf = movf || (v && mf == DEPTH);
      munf = munf || (fire && mf == 0);
      mp   = mp || (mf >= HALF);
      mph  = ph_n; minc = rate_word;
      mi   = mi_n; ml = ml_n; mc = mc_n; mf = mf_n;
    end
  end

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R11 reset state
    check(in_ready == 1'b1, "R11", in_ready, 1);
    check(out_valid == 1'b0, "R11", out_valid, 0);
    check(locked == 1'b0, "R11", locked, 0);
    check(ovf_flag == 1'b0 && unf_flag == 1'b0, "R11", {ovf_flag, unf_flag}, 0);
    check(rate_word == NOM, "R11", rate_word, NOM);
    #1 rst_n = 1'b1;
    run_model = 1'b1;

    // R3: seven beats, then a long wait with no reads
    drive_beats(7, 4);
    idle(40);
    check(reads_unprimed == 0, "R3", reads_unprimed, 0);

    // R8/R9: steady beats at the nominal rate lock the loop
    drive_beats(150, 4);
    check(locked == 1'b1, "R8", locked, 1);
    check(locked_cycles > 0, "R9", locked_cycles, 1);

    // R2/R7/R8: back-to-back burst overfills and unlocks
    drive_beats(40, 1);
    check(ovf_flag == 1'b1, "R2", ovf_flag, 1);
    check(locked == 1'b0, "R8", locked, 0);
    check(saw_max, "R7", saw_max, 1);

    // R10: drain to empty
    idle(300);
    check(unf_flag == 1'b1, "R10", unf_flag, 1);

    // R6/R7: sparse beats into a near-empty store drive the integral low
    drive_beats(30, 8);
    idle(20);
    check(saw_min, "R7", saw_min, 1);
    idle(300);
    check(pops > 0 && expq.size() == 0, "R1", expq.size(), 0);
    finish_run();
  end
endmodule